// File: doc/BRIEF.md
# Banked Stack-Pointer Register File with Fast-Interrupt Shadowing

This block is the architectural register storage of a 32-bit processor core. It keeps sixteen general registers. Index 0 is the stack pointer. It has no storage of its own: it is an alias onto one of two physical stack pointers. One serves interrupt context and the other serves user context. A selector bit in the status word picks between them, so a context switch needs no copy of the stack pointer.

The same block owns the program counter, the status word and a small set of control registers. These are the two table base addresses, the fast-interrupt vector, and the shadow copies of the PC and status word. A fast-interrupt strobe saves the PC and the status word into the shadows in a single clock. In that same clock it sends the PC to the programmed vector and switches the alias to the interrupt stack pointer. A return strobe restores both values in one clock.

Decode logic drives two combinational read ports, one write port, a PC load port and a control-register port. The control port selects its register with a 3-bit code and serves both reads and writes.

Top module: `spbank_regfile`

## Requirements
- R1: After reset every general register, both stack pointers, the PC, the status word and every control register read as zero, and `sp_misaligned` is 0.
- R2: A write to index 1..15 is returned by either read port at that index from the next cycle onward. The other indices are unchanged.
- R3: Index 0 reads and writes the interrupt stack pointer when status bit 17 (the stack selector) is 0, and the user stack pointer when it is 1.
- R4: When a read port addresses the index being written in the same cycle, it returns the write data in that cycle. The alias resolution for index 0 applies here too.
- R5: On `fint_take` the backup PC takes the current PC and the backup status takes the whole current status word, visible from the next cycle.
- R6: On `fint_take` the next PC is the fast-interrupt vector. The next status word is the current one with bit 17 cleared, so index 0 moves to the interrupt stack pointer at once.
- R7: On `fint_take`, the saved values override any control-port write to the backup PC, backup status or status word, and any PC load, in that same cycle.
- R8: On `fint_ret` without `fint_take`, the PC reloads from the backup PC and the status word from the backup status. When both strobes are high, `fint_take` wins.
- R9: Control-port codes are: 0 status word, 1 interrupt SP, 2 user SP, 3 interrupt table base, 4 exception table base, 5 fast vector, 6 backup PC, 7 backup status. A write with `cr_wr_en` lands on the next cycle, and `cr_rd_data` shows the stored value of the register `cr_sel` selects.
- R10: `sp_misaligned` is 1 exactly when the two low bits of the stack pointer chosen by the current bit 17 are not both zero.
- R11: `pc_wr_en` loads `pc_wr_data` into the PC on the next cycle when neither interrupt strobe is high.
- R12: When the write port writes index 0 and the control port writes the same stack pointer in the same cycle, the write-port data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| rd_addr_a | input | 4 | Read port A index |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 4 | Read port B index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| pc_wr_en | input | 1 | PC load enable |
| pc_wr_data | input | 32 | PC load value |
| cr_sel | input | 3 | Control register code |
| cr_wr_en | input | 1 | Control register write enable |
| cr_wr_data | input | 32 | Control register write data |
| cr_rd_data | output | 32 | Selected control register value |
| fint_take | input | 1 | Fast-interrupt entry strobe |
| fint_ret | input | 1 | Fast-interrupt return strobe |
| pc | output | 32 | Current program counter |
| psw | output | 32 | Current status word |
| sp_misaligned | output | 1 | Active stack pointer not 4-byte aligned |

## Verification
Assertions check the following on every cycle: the interrupt save of PC and status, the vector redirect with the selector cleared, the return restore, the PC load when no strobe is present, and where an index-0 write lands for each selector value. Other behaviours only show up when a scenario arranges them. These are write-through bypass, the write-port-over-control-port rule on a stack pointer, the override of shadow writes in an interrupt cycle, the alignment flag after a stack pointer change, and the table base registers. A behavioural reference model compares every output on every clock through directed scenarios and a long randomized stretch.

// File: rtl/regf_pkg.sv
package regf_pkg;

    localparam int CR_SEL_W = 3;

    typedef enum logic [CR_SEL_W-1:0] {
        CR_PSW  = 3'd0,
        CR_ISP  = 3'd1,
        CR_USP  = 3'd2,
        CR_ITB  = 3'd3,
        CR_ETB  = 3'd4,
        CR_FVEC = 3'd5,
        CR_BPC  = 3'd6,
        CR_BPSW = 3'd7
    } cr_sel_e;

endpackage

// File: rtl/regf_gpr_bank.sv
module regf_gpr_bank #(
    parameter int DW   = 32,
    parameter int NREG = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(NREG)-1:0]  waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [DW-1:0]            sp_active,
    output logic [NREG*DW-1:0]       rows_o
);
    localparam int AW = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:1][DW-1:0] row;
    } gpr_state_t;

    gpr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 1; i < NREG; i++) begin
            if (we && waddr == AW'(i)) begin
                st_d.row[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_rows
        if (g == 0) begin : g_alias
            assign rows_o[g*DW +: DW] = sp_active;
        end else begin : g_plain
            assign rows_o[g*DW +: DW] = st_q.row[g];
        end
    end

endmodule

// File: rtl/regf_sp_bank.sv
module regf_sp_bank
    import regf_pkg::*;
#(
    parameter int DW         = 32,
    parameter int NREG       = 16,
    parameter int ALIGN_BITS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     u_sel,
    input  logic                     gpr_we,
    input  logic [$clog2(NREG)-1:0]  gpr_waddr,
    input  logic [DW-1:0]            gpr_wdata,
    input  logic                     cr_we,
    input  logic [CR_SEL_W-1:0]      cr_sel,
    input  logic [DW-1:0]            cr_wdata,
    output logic [DW-1:0]            sp_active,
    output logic [DW-1:0]            isp,
    output logic [DW-1:0]            usp,
    output logic                     misaligned
);
    typedef struct packed {
        logic [DW-1:0] isp;
        logic [DW-1:0] usp;
    } sp_state_t;

    sp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cr_we && cr_sel == CR_ISP) begin
            st_d.isp = cr_wdata;
        end
        if (cr_we && cr_sel == CR_USP) begin
            st_d.usp = cr_wdata;
        end
        // the general write port is applied last so it takes precedence
        if (gpr_we && gpr_waddr == '0) begin
            if (u_sel) begin
                st_d.usp = gpr_wdata;
            end else begin
                st_d.isp = gpr_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign isp        = st_q.isp;
    assign usp        = st_q.usp;
    assign sp_active  = u_sel ? st_q.usp : st_q.isp;
    assign misaligned = |sp_active[ALIGN_BITS-1:0];

endmodule

// File: rtl/regf_sys_ctrl.sv
module regf_sys_ctrl
    import regf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int U_BIT = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pc_we,
    input  logic [DW-1:0]        pc_wdata,
    input  logic                 cr_we,
    input  logic [CR_SEL_W-1:0]  cr_sel,
    input  logic [DW-1:0]        cr_wdata,
    input  logic                 fint_take,
    input  logic                 fint_ret,
    input  logic [DW-1:0]        isp,
    input  logic [DW-1:0]        usp,
    output logic [DW-1:0]        pc,
    output logic [DW-1:0]        psw,
    output logic [DW-1:0]        bpc,
    output logic [DW-1:0]        bpsw,
    output logic [DW-1:0]        fvec,
    output logic [DW-1:0]        cr_rdata
);
    typedef struct packed {
        logic [DW-1:0] pc;
        logic [DW-1:0] psw;
        logic [DW-1:0] bpc;
        logic [DW-1:0] bpsw;
        logic [DW-1:0] fvec;
        logic [DW-1:0] itb;
        logic [DW-1:0] etb;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cr_we) begin
            case (cr_sel)
                CR_PSW:  st_d.psw  = cr_wdata;
                CR_ITB:  st_d.itb  = cr_wdata;
                CR_ETB:  st_d.etb  = cr_wdata;
                CR_FVEC: st_d.fvec = cr_wdata;
                CR_BPC:  st_d.bpc  = cr_wdata;
                CR_BPSW: st_d.bpsw = cr_wdata;
                default: ;
            endcase
        end
        if (pc_we) begin
            st_d.pc = pc_wdata;
        end
        // interrupt events are applied last: entry first, then return
        if (fint_take) begin
            st_d.bpc        = st_q.pc;
            st_d.bpsw       = st_q.psw;
            st_d.pc         = st_q.fvec;
            st_d.psw        = st_q.psw;
            st_d.psw[U_BIT] = 1'b0;
        end else if (fint_ret) begin
            st_d.pc  = st_q.bpc;
            st_d.psw = st_q.bpsw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (cr_sel)
            CR_PSW:  cr_rdata = st_q.psw;
            CR_ISP:  cr_rdata = isp;
            CR_USP:  cr_rdata = usp;
            CR_ITB:  cr_rdata = st_q.itb;
            CR_ETB:  cr_rdata = st_q.etb;
            CR_FVEC: cr_rdata = st_q.fvec;
            CR_BPC:  cr_rdata = st_q.bpc;
            default: cr_rdata = st_q.bpsw;
        endcase
    end

    assign pc   = st_q.pc;
    assign psw  = st_q.psw;
    assign bpc  = st_q.bpc;
    assign bpsw = st_q.bpsw;
    assign fvec = st_q.fvec;

endmodule

// File: rtl/regf_read_port.sv
module regf_read_port #(
    parameter int DW   = 32,
    parameter int NREG = 16
) (
    input  logic [NREG*DW-1:0]       rows,
    input  logic [$clog2(NREG)-1:0]  raddr,
    input  logic                     we,
    input  logic [$clog2(NREG)-1:0]  waddr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] stored;

    assign stored = rows[raddr*DW +: DW];
    assign rdata  = (we && waddr == raddr) ? wdata : stored;

endmodule

// File: rtl/spbank_regfile.sv
module spbank_regfile
    import regf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NREG  = 16,
    parameter int U_BIT = 17
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NREG)-1:0]  rd_addr_a,
    output logic [DW-1:0]            rd_data_a,
    input  logic [$clog2(NREG)-1:0]  rd_addr_b,
    output logic [DW-1:0]            rd_data_b,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     pc_wr_en,
    input  logic [DW-1:0]            pc_wr_data,
    input  logic [CR_SEL_W-1:0]      cr_sel,
    input  logic                     cr_wr_en,
    input  logic [DW-1:0]            cr_wr_data,
    output logic [DW-1:0]            cr_rd_data,
    input  logic                     fint_take,
    input  logic                     fint_ret,
    output logic [DW-1:0]            pc,
    output logic [DW-1:0]            psw,
    output logic                     sp_misaligned
);
    localparam int AW  = $clog2(NREG);
    localparam int NRD = 2;

    logic [DW-1:0]      sp_active;
    logic [DW-1:0]      isp_w, usp_w;
    logic [DW-1:0]      bpc_w, bpsw_w, fvec_w;
    logic [NREG*DW-1:0] rows;
    logic [AW-1:0]      rp_addr [NRD];
    logic [DW-1:0]      rp_data [NRD];

    regf_sp_bank #(.DW(DW), .NREG(NREG), .ALIGN_BITS(2)) u_sp (
        .clk        (clk),
        .rst_n      (rst_n),
        .u_sel      (psw[U_BIT]),
        .gpr_we     (wr_en),
        .gpr_waddr  (wr_addr),
        .gpr_wdata  (wr_data),
        .cr_we      (cr_wr_en),
        .cr_sel     (cr_sel),
        .cr_wdata   (cr_wr_data),
        .sp_active  (sp_active),
        .isp        (isp_w),
        .usp        (usp_w),
        .misaligned (sp_misaligned)
    );

    regf_gpr_bank #(.DW(DW), .NREG(NREG)) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .waddr     (wr_addr),
        .wdata     (wr_data),
        .sp_active (sp_active),
        .rows_o    (rows)
    );

    regf_sys_ctrl #(.DW(DW), .U_BIT(U_BIT)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pc_we     (pc_wr_en),
        .pc_wdata  (pc_wr_data),
        .cr_we     (cr_wr_en),
        .cr_sel    (cr_sel),
        .cr_wdata  (cr_wr_data),
        .fint_take (fint_take),
        .fint_ret  (fint_ret),
        .isp       (isp_w),
        .usp       (usp_w),
        .pc        (pc),
        .psw       (psw),
        .bpc       (bpc_w),
        .bpsw      (bpsw_w),
        .fvec      (fvec_w),
        .cr_rdata  (cr_rd_data)
    );

    assign rp_addr[0] = rd_addr_a;
    assign rp_addr[1] = rd_addr_b;

    for (genvar p = 0; p < NRD; p++) begin : g_rport
        regf_read_port #(.DW(DW), .NREG(NREG)) u_rp (
            .rows  (rows),
            .raddr (rp_addr[p]),
            .we    (wr_en),
            .waddr (wr_addr),
            .wdata (wr_data),
            .rdata (rp_data[p])
        );
    end

    assign rd_data_a = rp_data[0];
    assign rd_data_b = rp_data[1];

endmodule

// File: rtl/spbank_regfile_chk.sv
module spbank_regfile_chk #(
    parameter int DW    = 32,
    parameter int AW    = 4,
    parameter int U_BIT = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          pc_wr_en,
    input logic [DW-1:0] pc_wr_data,
    input logic          fint_take,
    input logic          fint_ret,
    input logic [DW-1:0] pc,
    input logic [DW-1:0] psw,
    input logic [DW-1:0] bpc,
    input logic [DW-1:0] bpsw,
    input logic [DW-1:0] fvec,
    input logic [DW-1:0] isp,
    input logic [DW-1:0] usp
);
    localparam logic [DW-1:0] U_MASK = DW'(1) << U_BIT;

    // R5
    fint_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fint_take |=> (bpc == $past(pc) && bpsw == $past(psw)));

    // R6
    fint_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fint_take |=> (pc == $past(fvec) && psw == ($past(psw) & ~U_MASK)));

    // R8
    fint_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fint_ret && !fint_take) |=> (pc == $past(bpc) && psw == $past(bpsw)));

    // R11
    pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_en && !fint_take && !fint_ret) |=> (pc == $past(pc_wr_data)));

    // R3
    isp_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0 && !psw[U_BIT]) |=> (isp == $past(wr_data)));

    // R3
    usp_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0 && psw[U_BIT]) |=> (usp == $past(wr_data)));

endmodule

bind spbank_regfile spbank_regfile_chk #(.DW(DW), .AW($clog2(NREG)), .U_BIT(U_BIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pc_wr_en   (pc_wr_en),
    .pc_wr_data (pc_wr_data),
    .fint_take  (fint_take),
    .fint_ret   (fint_ret),
    .pc         (pc),
    .psw        (psw),
    .bpc        (bpc_w),
    .bpsw       (bpsw_w),
    .fvec       (fvec_w),
    .isp        (isp_w),
    .usp        (usp_w)
);

// File: tb/spbank_regfile_test.sv
module spbank_regfile_test;
    localparam int CLK_PERIOD = 10;
    localparam int U = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b, cr_rd_data, pc, psw;
    logic        wr_en = 1'b0, pc_wr_en = 1'b0, cr_wr_en = 1'b0;
    logic        fint_take = 1'b0, fint_ret = 1'b0;
    logic [31:0] wr_data = '0, pc_wr_data = '0, cr_wr_data = '0;
    logic [2:0]  cr_sel = '0;
    logic        sp_misaligned;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic [31:0] m_gpr [16];
    logic [31:0] m_isp, m_usp, m_pc, m_psw, m_bpc, m_bpsw, m_fvec, m_itb, m_etb;

    always #(CLK_PERIOD/2) clk = ~clk;

    spbank_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
        .cr_sel(cr_sel), .cr_wr_en(cr_wr_en), .cr_wr_data(cr_wr_data),
        .cr_rd_data(cr_rd_data),
        .fint_take(fint_take), .fint_ret(fint_ret),
        .pc(pc), .psw(psw), .sp_misaligned(sp_misaligned)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_active_sp();
        return m_psw[U] ? m_usp : m_isp;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        logic [31:0] v;
        v = (a == 4'd0) ? m_active_sp() : m_gpr[a];
        if (wr_en && wr_addr == a) v = wr_data;
        return v;
    endfunction

    function automatic logic [31:0] m_cr();
        case (cr_sel)
            3'd0: return m_psw;
            3'd1: return m_isp;
            3'd2: return m_usp;
            3'd3: return m_itb;
            3'd4: return m_etb;
            3'd5: return m_fvec;
            3'd6: return m_bpc;
            default: return m_bpsw;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_gpr[i] = '0;
        m_isp = '0; m_usp = '0; m_pc = '0; m_psw = '0; m_bpc = '0;
        m_bpsw = '0; m_fvec = '0; m_itb = '0; m_etb = '0;
    endtask

    task automatic model_step();
        logic [31:0] n_isp, n_usp, n_pc, n_psw, n_bpc, n_bpsw;
        n_isp = m_isp; n_usp = m_usp; n_pc = m_pc; n_psw = m_psw;
        n_bpc = m_bpc; n_bpsw = m_bpsw;
        if (cr_wr_en) begin
            case (cr_sel)
                3'd0: n_psw = cr_wr_data;
                3'd1: n_isp = cr_wr_data;
                3'd2: n_usp = cr_wr_data;
                3'd3: m_itb = cr_wr_data;
                3'd4: m_etb = cr_wr_data;
                3'd5: ;
                3'd6: n_bpc = cr_wr_data;
                default: n_bpsw = cr_wr_data;
            endcase
        end
        if (wr_en) begin
            if (wr_addr == 4'd0) begin
                if (m_psw[U]) n_usp = wr_data; else n_isp = wr_data;
            end else begin
                m_gpr[wr_addr] = wr_data;
            end
        end
        if (pc_wr_en) n_pc = pc_wr_data;
        if (fint_take) begin
            n_bpc = m_pc; n_bpsw = m_psw; n_pc = m_fvec;
            n_psw = m_psw & ~(32'd1 << U);
        end else if (fint_ret) begin
            n_pc = m_bpc; n_psw = m_bpsw;
        end
        if (cr_wr_en && cr_sel == 3'd5) m_fvec = cr_wr_data;
        m_isp = n_isp; m_usp = n_usp; m_pc = n_pc; m_psw = n_psw;
        m_bpc = n_bpc; m_bpsw = n_bpsw;
    endtask

    task automatic idle();
        wr_en = 0; pc_wr_en = 0; cr_wr_en = 0; fint_take = 0; fint_ret = 0;
    endtask

    // inputs are set at a falling edge; compare, advance model, wait
    task automatic cycle(input string req);
        #1;
        check(req, "rd_data_a", rd_data_a, m_read(rd_addr_a));
        check(req, "rd_data_b", rd_data_b, m_read(rd_addr_b));
        check(req, "cr_rd_data", cr_rd_data, m_cr());
        check(req, "pc", pc, m_pc);
        check(req, "psw", psw, m_psw);
        check(req, "sp_misaligned", {31'd0, sp_misaligned}, {31'd0, |m_active_sp()[1:0]});
        model_step();
        @(negedge clk);
        idle();
    endtask

    task automatic gwrite(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
    endtask

    task automatic cwrite(input logic [2:0] s, input logic [31:0] d);
        cr_wr_en = 1; cr_sel = s; cr_wr_data = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every stored value reads zero after reset
        for (int s = 0; s < 8; s++) begin
            cr_sel = 3'(s); rd_addr_a = 4'(s); rd_addr_b = 4'(s + 8);
            cycle("R1");
        end

        // R2: plain registers, both ports
        gwrite(4'd5, 32'hA5A5_0001); cycle("R2");
        gwrite(4'd15, 32'h0BAD_F00D); cycle("R2");
        rd_addr_a = 4'd5; rd_addr_b = 4'd15; cycle("R2");
        rd_addr_a = 4'd6; rd_addr_b = 4'd1; cycle("R2");

        // R4: same-cycle bypass, including index 0
        rd_addr_a = 4'd7; rd_addr_b = 4'd0;
        gwrite(4'd7, 32'h7777_0007); cycle("R4");
        gwrite(4'd0, 32'h0000_1000); cycle("R4");

        // R3: alias follows bit 17
        rd_addr_a = 4'd0; cr_sel = 3'd1; cycle("R3");
        cwrite(3'd0, 32'h0002_0000); cycle("R3");
        gwrite(4'd0, 32'h0000_2000); cycle("R3");
        cr_sel = 3'd2; cycle("R3");
        cr_sel = 3'd1; cycle("R3");

        // R12: write port beats control port on the same stack pointer
        gwrite(4'd0, 32'h0000_3000); cwrite(3'd2, 32'h0000_4444); cycle("R12");
        cr_sel = 3'd2; cycle("R12");

        // R10: misaligned stack pointer in either bank
        gwrite(4'd0, 32'h0000_3002); cycle("R10");
        cycle("R10");
        cwrite(3'd0, 32'h0000_0000); cycle("R10");
        cwrite(3'd1, 32'h0000_0001); cycle("R10");
        cycle("R10");

        // R9: table bases and vector
        cwrite(3'd3, 32'h0001_0000); cycle("R9");
        cwrite(3'd4, 32'h0002_0000); cycle("R9");
        cwrite(3'd5, 32'h0000_8000); cycle("R9");
        for (int s = 3; s < 6; s++) begin cr_sel = 3'(s); cycle("R9"); end

        // R11: PC load
        pc_wr_en = 1; pc_wr_data = 32'h0000_0400; cycle("R11");
        cycle("R11");

        // R5 / R6: entry from user context
        cwrite(3'd0, 32'h0002_00C3); cycle("R6");
        fint_take = 1; rd_addr_a = 4'd0; cycle("R5");
        cr_sel = 3'd6; cycle("R5");
        cr_sel = 3'd7; cycle("R5");

        // R8: return restores user context
        fint_ret = 1; cycle("R8");
        cycle("R8");

        // R7: entry overrides shadow, status and PC writes in the same cycle
        fint_take = 1; pc_wr_en = 1; pc_wr_data = 32'h1234_5678;
        cwrite(3'd6, 32'hDEAD_BEEF); cycle("R7");
        fint_take = 1; cwrite(3'd7, 32'hFFFF_FFFF); cycle("R7");
        fint_take = 1; cwrite(3'd0, 32'h0002_0001); cycle("R7");
        cr_sel = 3'd6; cycle("R7");

        // R8: both strobes high, entry wins
        fint_take = 1; fint_ret = 1; cycle("R8");
        cr_sel = 3'd7; cycle("R8");

        // randomized stretch, all outputs against the model
        for (int n = 0; n < 4000; n++) begin
            rd_addr_a = 4'($urandom_range(0, 15));
            rd_addr_b = ($urandom_range(0, 3) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
            cr_sel    = 3'($urandom_range(0, 7));
            wr_en     = ($urandom_range(0, 1) == 1);
            wr_addr   = ($urandom_range(0, 3) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
            wr_data   = $urandom();
            if ($urandom_range(0, 1) == 1) wr_data[1:0] = 2'b00;
            cr_wr_en  = ($urandom_range(0, 4) == 0);
            cr_wr_data = $urandom();
            pc_wr_en  = ($urandom_range(0, 2) == 0);
            pc_wr_data = $urandom();
            fint_take = ($urandom_range(0, 19) == 0);
            fint_ret  = ($urandom_range(0, 19) == 0);
            cycle("R2 random");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule